// File: doc/BRIEF.md
# Subroutine Call Stack-Push Sequencer

This block performs the stack half of a subroutine call in a 16-bit segmented processor. When a start pulse arrives, it captures the call kind (near or far), the target segment and offset, the current code segment, instruction pointer and stack pointer, and the data-bus width. It then writes the return information onto the stack through a simple write port that moves one transfer at a time, and it updates the three pointer registers in the order a segmented call defines.

A far call first pushes the code segment, then loads the new segment, then pushes the instruction pointer, and finally loads the new offset. A near call pushes only the instruction pointer and loads only the offset. On a 16-bit bus each word is a single word transfer. On an 8-bit bus each word is split into two byte transfers. The sequencer pads with idle cycles so that every call takes a fixed number of cycles for its kind and bus width. A slow memory that holds ready low adds cycles on top of that fixed count.

Top module: `call_push_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are low, and `sp_out`, `cs_out` and `ip_out` are zero.
- R2: For a far call (`far_call`=1), the first push stores the captured CS at SP-2. `cs_out` already shows the target segment while the second push stores the captured IP at SP-4. At completion SP is the captured SP minus 4, CS is the target segment and IP is the target offset.
- R3: For a near call (`far_call`=0), the only push stores the captured IP at SP-2. At completion CS is unchanged, IP is the target offset and SP is the captured SP minus 2.
- R4: With `narrow_bus`=0, each word push is one transfer with `mem_wide`=1. `mem_addr` holds the word address, which is the address of the low byte. `mem_wdata[7:0]` carries the low byte and `mem_wdata[15:8]` carries the high byte, which belongs at address+1.
- R5: With `narrow_bus`=1, each word push is two transfers with `mem_wide`=0. The first carries the low byte at the word address. The second carries the high byte at the word address+1. Both bytes travel on `mem_wdata[7:0]`, and `mem_wdata[15:8]` is zero.
- R6: With `mem_ready` held high, the number of cycles in which `busy` is high, counting the `done` cycle, is fixed by the call kind and bus width: far/16-bit 28, far/8-bit 36, near/16-bit 19, near/8-bit 23.
- R7: While `mem_we` is high and `mem_ready` is low, `mem_we`, `mem_addr`, `mem_wdata` and `mem_wide` stay unchanged. Each such stall cycle adds exactly one cycle to the R6 total.
- R8: All SP arithmetic and push addresses wrap modulo 2^16, and each SP change inside a call is a step of -2.
- R9: A start pulse that arrives while `busy` is high is ignored. It does not change the running call's pushes, results or length, and no second call follows.
- R10: `done` is high for exactly one cycle, which is the last busy cycle. The final register values are visible in that cycle and stay unchanged while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a call (sampled only while idle) |
| far_call | input | 1 | 1 = inter-segment call, 0 = near call |
| narrow_bus | input | 1 | 1 = 8-bit data bus, 0 = 16-bit data bus |
| tgt_seg | input | 16 | Destination code segment |
| tgt_off | input | 16 | Destination offset |
| cur_cs | input | 16 | Code segment at call time |
| cur_ip | input | 16 | Return offset at call time |
| cur_sp | input | 16 | Stack pointer at call time |
| mem_ready | input | 1 | Memory accepts the current transfer |
| mem_we | output | 1 | Write transfer pending |
| mem_wide | output | 1 | 1 = word transfer, 0 = byte transfer |
| mem_addr | output | 16 | Transfer address (stack offset) |
| mem_wdata | output | 16 | Transfer data |
| sp_out | output | 16 | Stack pointer register |
| cs_out | output | 16 | Code segment register |
| ip_out | output | 16 | Instruction pointer register |
| busy | output | 1 | Call in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default budget parameters (28 and 19 cycles, plus 4 per word on a narrow bus). Those values make all four fixed totals directly comparable with the constants stated in R6. Stack pointers near zero bring the address wrap within reach, and a memory model that stalls each transfer for 0 to 3 cycles shows that stalls add to the budget instead of being absorbed by it. A second start pulse during a call exercises the ignore rule.

// File: rtl/call_push_pkg.sv
package call_push_pkg;

    localparam int CPS_W  = 16;
    localparam int CPS_HB = CPS_W / 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_PAD,
        ST_DONE
    } cps_state_e;

    typedef struct packed {
        logic             far_call;
        logic             narrow;
        logic [CPS_W-1:0] seg;
        logic [CPS_W-1:0] off;
        logic [CPS_W-1:0] cs;
        logic [CPS_W-1:0] ip;
    } cps_req_t;

    typedef struct packed {
        logic [CPS_W-1:0] addr;
        logic [CPS_W-1:0] data;
        logic             wide;
    } cps_xfer_t;

    // Total busy cycles of one call, done cycle included, with no stalls.
    function automatic int cps_budget(input logic far_call, input logic narrow,
                                      input int far_cyc, input int near_cyc,
                                      input int extra);
        int words;
        int base;
        words = far_call ? 2 : 1;
        base  = far_call ? far_cyc : near_cyc;
        return narrow ? base + words * extra : base;
    endfunction

endpackage

// File: rtl/call_push_xfer.sv
module call_push_xfer
    import call_push_pkg::*;
(
    input  logic [CPS_W-1:0] word_data,
    input  logic [CPS_W-1:0] sp,
    input  logic             narrow,
    input  logic             hi_phase,
    output cps_xfer_t        xfer
);
    logic             hi_sel;
    logic [CPS_W-1:0] word_addr;

    assign hi_sel    = narrow & hi_phase;
    assign word_addr = sp - CPS_W'(2);

    always_comb begin
        xfer.addr = word_addr + CPS_W'(hi_sel);
        xfer.wide = ~narrow;
        if (!narrow) begin
            xfer.data = word_data;
        end else if (hi_phase) begin
            xfer.data = {{CPS_HB{1'b0}}, word_data[CPS_W-1:CPS_HB]};
        end else begin
            xfer.data = {{CPS_HB{1'b0}}, word_data[CPS_HB-1:0]};
        end
    end
endmodule

// File: rtl/call_push_pacer.sv
module call_push_pacer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             at_end
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // High in the cycle that precedes the done cycle.
    assign at_end = ({1'b0, cnt} + (CNT_W+1)'(2)) >= {1'b0, target};
endmodule

// File: rtl/call_push_seq.sv
module call_push_seq
    import call_push_pkg::*;
#(
    parameter int FAR_CYCLES   = 28,
    parameter int NEAR_CYCLES  = 19,
    parameter int NARROW_EXTRA = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        far_call,
    input  logic        narrow_bus,
    input  logic [15:0] tgt_seg,
    input  logic [15:0] tgt_off,
    input  logic [15:0] cur_cs,
    input  logic [15:0] cur_ip,
    input  logic [15:0] cur_sp,
    input  logic        mem_ready,
    output logic        mem_we,
    output logic        mem_wide,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic [15:0] sp_out,
    output logic [15:0] cs_out,
    output logic [15:0] ip_out,
    output logic        busy,
    output logic        done
);
    localparam int MAX_FAR  = FAR_CYCLES + 2 * NARROW_EXTRA;
    localparam int MAX_NEAR = NEAR_CYCLES + NARROW_EXTRA;
    localparam int MAX_CYC  = (MAX_FAR > MAX_NEAR) ? MAX_FAR : MAX_NEAR;
    localparam int CNT_W    = $clog2(MAX_CYC + 1) + 1;

    cps_state_e       state;
    cps_req_t         req;
    logic [CPS_W-1:0] sp_r, cs_r, ip_r;
    logic             word_ix;   // 0 = segment word, 1 = return-offset word
    logic             hi_phase;
    logic             accept, xfer_ok, word_end, at_end;
    logic [CNT_W-1:0] target;
    cps_xfer_t        xfer;

    assign accept   = (state == ST_IDLE) && start;
    assign xfer_ok  = (state == ST_XFER) && mem_ready;
    assign word_end = xfer_ok && (!req.narrow || hi_phase);
    assign target   = CNT_W'(cps_budget(req.far_call, req.narrow,
                                        FAR_CYCLES, NEAR_CYCLES, NARROW_EXTRA));

    call_push_xfer u_xfer (
        .word_data (word_ix ? req.ip : req.cs),
        .sp        (sp_r),
        .narrow    (req.narrow),
        .hi_phase  (hi_phase),
        .xfer      (xfer)
    );

    call_push_pacer #(.CNT_W(CNT_W)) u_pacer (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .tick   (xfer_ok || (state == ST_PAD)),
        .target (target),
        .at_end (at_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            req      <= '0;
            sp_r     <= '0;
            cs_r     <= '0;
            ip_r     <= '0;
            word_ix  <= 1'b0;
            hi_phase <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        req.far_call <= far_call;
                        req.narrow   <= narrow_bus;
                        req.seg      <= tgt_seg;
                        req.off      <= tgt_off;
                        req.cs       <= cur_cs;
                        req.ip       <= cur_ip;
                        sp_r         <= cur_sp;
                        cs_r         <= cur_cs;
                        ip_r         <= cur_ip;
                        word_ix      <= ~far_call;
                        hi_phase     <= 1'b0;
                        state        <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (xfer_ok && !word_end) begin
                        hi_phase <= 1'b1;
                    end
                    if (word_end) begin
                        hi_phase <= 1'b0;
                        sp_r     <= sp_r - CPS_W'(2);
                        if (!word_ix) begin
                            cs_r    <= req.seg;
                            word_ix <= 1'b1;
                        end else begin
                            ip_r  <= req.off;
                            state <= at_end ? ST_DONE : ST_PAD;
                        end
                    end
                end
                ST_PAD: begin
                    if (at_end) begin
                        state <= ST_DONE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign mem_we    = (state == ST_XFER);
    assign mem_wide  = xfer.wide;
    assign mem_addr  = xfer.addr;
    assign mem_wdata = xfer.data;
    assign sp_out    = sp_r;
    assign cs_out    = cs_r;
    assign ip_out    = ip_r;
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);
endmodule

// File: rtl/call_push_chk.sv
module call_push_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_ready,
    input logic        mem_we,
    input logic        mem_wide,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic [15:0] sp_out,
    input logic [15:0] cs_out,
    input logic [15:0] ip_out,
    input logic        busy,
    input logic        done
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !done));

    p_byte_lane_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_wide) |-> (mem_wdata[15:8] == 8'h00));

    p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) &&
                                    $stable(mem_wdata) && $stable(mem_wide)));

    p_sp_step_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (sp_out != $past(sp_out)))
            |-> (sp_out == $past(sp_out) - 16'd2));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_regs_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ($stable(sp_out) && $stable(cs_out) && $stable(ip_out)));

    p_no_write_at_done_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_we);
endmodule

bind call_push_seq call_push_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_wide  (mem_wide),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sp_out    (sp_out),
    .cs_out    (cs_out),
    .ip_out    (ip_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/call_push_seq_tb.sv
module call_push_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, far_call = 1'b0, narrow_bus = 1'b0;
    logic [15:0] tgt_seg = '0, tgt_off = '0, cur_cs = '0, cur_ip = '0, cur_sp = '0;
    logic        mem_ready = 1'b1;
    logic        mem_we, mem_wide, busy, done;
    logic [15:0] mem_addr, mem_wdata, sp_out, cs_out, ip_out;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    call_push_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .far_call(far_call),
        .narrow_bus(narrow_bus), .tgt_seg(tgt_seg), .tgt_off(tgt_off),
        .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_sp(cur_sp),
        .mem_ready(mem_ready), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sp_out(sp_out),
        .cs_out(cs_out), .ip_out(ip_out), .busy(busy), .done(done)
    );

    // {far, narrow, stall[1:0], seg, off, cs, ip, sp}
    localparam int NV = 7;
    localparam logic [83:0] VEC [NV] = '{
        {1'b1, 1'b0, 2'd0, 16'hF000, 16'h1234, 16'h2000, 16'h0100, 16'hFFFE},
        {1'b1, 1'b1, 2'd0, 16'h0040, 16'h0008, 16'h1357, 16'h2468, 16'h0100},
        {1'b0, 1'b0, 2'd0, 16'h9999, 16'h4321, 16'h0A0B, 16'h0C0D, 16'h8000},
        {1'b0, 1'b1, 2'd0, 16'h7777, 16'h00FF, 16'h1111, 16'hABCD, 16'h0200},
        {1'b1, 1'b1, 2'd2, 16'h0001, 16'h0002, 16'hBEEF, 16'hCAFE, 16'h0001},
        {1'b0, 1'b0, 2'd3, 16'h4444, 16'h5678, 16'h3333, 16'h1234, 16'h0000},
        {1'b1, 1'b0, 2'd1, 16'h1000, 16'h2000, 16'h8001, 16'h7FFE, 16'h0003}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected transfer list, built from R2..R5.
    logic [15:0] e_addr [4];
    logic [15:0] e_data [4];
    logic        e_wide [4];
    logic [15:0] e_cs   [4];   // cs_out seen while each transfer completes
    int          e_n;

    // Observed transfer list
    logic [15:0] o_addr [4];
    logic [15:0] o_data [4];
    logic        o_wide [4];
    logic [15:0] o_cs   [4];
    int          o_n;
    int          o_cyc;
    logic [15:0] f_sp, f_cs, f_ip;

    task automatic add_word(input logic [15:0] a, input logic [15:0] w,
                            input logic nar, input logic [15:0] csv);
        if (!nar) begin
            e_addr[e_n] = a; e_data[e_n] = w; e_wide[e_n] = 1'b1; e_cs[e_n] = csv; e_n++;
        end else begin
            e_addr[e_n] = a;         e_data[e_n] = {8'h00, w[7:0]};
            e_wide[e_n] = 1'b0;      e_cs[e_n] = csv; e_n++;
            e_addr[e_n] = a + 16'd1; e_data[e_n] = {8'h00, w[15:8]};
            e_wide[e_n] = 1'b0;      e_cs[e_n] = csv; e_n++;
        end
    endtask

    // Runs one call; optional second start pulse after 'extra_at' busy cycles.
    task automatic run_call(input logic fr, input logic nar, input int stall,
                            input logic [15:0] seg, input logic [15:0] off,
                            input logic [15:0] cs, input logic [15:0] ip,
                            input logic [15:0] sp, input int extra_at);
        int wait_left;
        int guard;
        @(negedge clk);
        far_call = fr; narrow_bus = nar; tgt_seg = seg; tgt_off = off;
        cur_cs = cs; cur_ip = ip; cur_sp = sp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        o_n = 0; o_cyc = 0; wait_left = stall; guard = 0;
        mem_ready = 1'b1;
        forever begin
            if (busy) o_cyc++;
            if (extra_at > 0 && o_cyc == extra_at) begin
                start = 1'b1; far_call = ~fr; narrow_bus = ~nar;
                tgt_seg = 16'h5A5A; tgt_off = 16'hA5A5; cur_sp = 16'h7000;
            end else begin
                start = 1'b0;
            end
            if (mem_we) begin
                if (wait_left > 0) begin
                    mem_ready = 1'b0; wait_left--;
                end else begin
                    mem_ready = 1'b1;
                    if (o_n < 4) begin
                        o_addr[o_n] = mem_addr; o_data[o_n] = mem_wdata;
                        o_wide[o_n] = mem_wide; o_cs[o_n] = cs_out;
                    end
                    o_n++;
                    wait_left = stall;
                end
            end else begin
                mem_ready = 1'b1;
            end
            if (done) begin
                f_sp = sp_out; f_cs = cs_out; f_ip = ip_out;
                break;
            end
            guard++;
            if (guard > 1000) begin
                check(1'b0, "WATCHDOG", "call never finished", 32'(guard), 32'd0);
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        mem_ready = 1'b1;
    endtask

    task automatic verify(input logic fr, input logic nar, input int stall,
                          input logic [15:0] seg, input logic [15:0] off,
                          input logic [15:0] cs, input logic [15:0] ip,
                          input logic [15:0] sp);
        int budget;
        string tr;
        e_n = 0;
        tr = fr ? "R2" : "R3";
        if (fr) begin
            add_word(sp - 16'd2, cs, nar, cs);
            add_word(sp - 16'd4, ip, nar, seg);
        end else begin
            add_word(sp - 16'd2, ip, nar, cs);
        end
        budget = fr ? (nar ? 36 : 28) : (nar ? 23 : 19);
        check(o_n == e_n, tr, "transfer count", 32'(o_n), 32'(e_n));
        for (int k = 0; k < e_n && k < o_n; k++) begin
            check(o_addr[k] == e_addr[k], "R8", "push address",
                  32'(o_addr[k]), 32'(e_addr[k]));
            check(o_data[k] == e_data[k], nar ? "R5" : "R4", "push data",
                  32'(o_data[k]), 32'(e_data[k]));
            check(o_wide[k] == e_wide[k], nar ? "R5" : "R4", "transfer width",
                  32'(o_wide[k]), 32'(e_wide[k]));
            check(o_cs[k] == e_cs[k], "R2", "cs during push",
                  32'(o_cs[k]), 32'(e_cs[k]));
        end
        check(f_sp == (fr ? sp - 16'd4 : sp - 16'd2), tr, "final sp",
              32'(f_sp), 32'(fr ? sp - 16'd4 : sp - 16'd2));
        check(f_cs == (fr ? seg : cs), tr, "final cs", 32'(f_cs), 32'(fr ? seg : cs));
        check(f_ip == off, tr, "final ip", 32'(f_ip), 32'(off));
        check(o_cyc == budget + stall * e_n, stall > 0 ? "R7" : "R6", "busy cycles",
              32'(o_cyc), 32'(budget + stall * e_n));
        @(negedge clk);
        check(!done && !busy, "R10", "done lasts one cycle", {30'd0, done, busy}, 32'd0);
        check(sp_out == f_sp && cs_out == f_cs && ip_out == f_ip, "R10",
              "registers hold after done", 32'(sp_out), 32'(f_sp));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !done && !mem_we, "R1", "control outputs after reset",
              {29'd0, busy, done, mem_we}, 32'd0);
        check(sp_out == 16'd0 && cs_out == 16'd0 && ip_out == 16'd0, "R1",
              "registers after reset", {sp_out, cs_out}, 32'd0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            run_call(VEC[v][83], VEC[v][82], int'(VEC[v][81:80]), VEC[v][79:64],
                     VEC[v][63:48], VEC[v][47:32], VEC[v][31:16], VEC[v][15:0], 0);
            verify(VEC[v][83], VEC[v][82], int'(VEC[v][81:80]), VEC[v][79:64],
                   VEC[v][63:48], VEC[v][47:32], VEC[v][31:16], VEC[v][15:0]);
        end

        // R9: second start during a far 16-bit call is ignored
        run_call(1'b1, 1'b0, 0, 16'h0C00, 16'h00C0, 16'h0B00, 16'h00B0, 16'h4000, 5);
        verify(1'b1, 1'b0, 0, 16'h0C00, 16'h00C0, 16'h0B00, 16'h00B0, 16'h4000);
        repeat (3) begin
            @(negedge clk);
            check(!busy && !mem_we, "R9", "no call after ignored start",
                  {30'd0, busy, mem_we}, 32'd0);
        end

        // R9: second start during a narrow near call with stalls
        run_call(1'b0, 1'b1, 1, 16'h0E00, 16'h00E0, 16'h0D00, 16'h00D0, 16'h0002, 2);
        verify(1'b0, 1'b1, 1, 16'h0E00, 16'h00E0, 16'h0D00, 16'h00D0, 16'h0002);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #400000;
        n_errors++;
        n_checks++;
        $display("FAIL WATCHDOG global timeout: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule